// File: doc/BRIEF.md
# Privileged Interrupt Arbiter

This block decides, in the same cycle, whether one of a hart's pending interrupts is taken and which privilege level handles it. The inputs are the pending-and-enabled interrupt vector, the delegation mask, the current privilege mode and the two global enable bits, one for machine level and one for supervisor level. Each interrupt's target level comes from its delegation bit. The enable that applies to it comes from comparing that target with the current mode, not from one global bit.

The take decision, the winning cause index and the target mode are combinational. One register holds the wait-for-interrupt stall. The hart sets it by requesting a wait. Any nonzero pending vector clears it, whether or not an interrupt is taken. Trap entry, state saving and register access are left to the surrounding core.

Top module: `irq_arbiter`

## Requirements
- R1: An interrupt whose delegation bit is 0 targets M-mode (take_mode 2'b11). The supervisor enable has no effect on whether it is taken.
- R2: In M-mode (priv_mode 2'b11), an M-targeted interrupt is taken only when mie_bit is 1.
- R3: In S-mode (2'b01) or U-mode (2'b00), an M-targeted interrupt is taken whatever the value of mie_bit.
- R4: In S-mode, an interrupt delegated to S-mode (delegation bit 1, take_mode 2'b01) is taken only when sie_bit is 1. With sie_bit 0 it stays pending and is not taken.
- R5: In M-mode, an S-targeted interrupt is never taken, whatever sie_bit is.
- R6: In U-mode, an S-targeted interrupt is taken whatever the value of sie_bit.
- R7: When both an M-targeted and an S-targeted interrupt can be taken, the M-targeted one wins.
- R8: Within one target level the order, highest first, is bit 11, 3, 7, 9, 1, 5. take_cause carries the winning bit index.
- R9: When no interrupt can be taken, take_irq, take_cause and take_mode are all 0.
- R10: Only bits 1, 3, 5, 7, 9 and 11 take part in arbitration. The even bits never cause a take.
- R11: wfi_stall rises on the clock edge after wfi_req with a zero pending vector. Any nonzero pending vector (even-numbered bits included) raises wfi_wake in the same cycle while stalled and clears wfi_stall on the next edge, even when nothing is taken. A nonzero vector also overrides a wfi_req in the same cycle.
- R12: During reset wfi_stall and wfi_wake are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pend | input | 12 | Pending-and-enabled interrupt vector |
| irq_deleg | input | 12 | Delegation mask, 1 sends the bit to S-mode |
| priv_mode | input | 2 | Current mode: U=00, S=01, M=11 |
| mie_bit | input | 1 | Machine global interrupt enable |
| sie_bit | input | 1 | Supervisor global interrupt enable |
| wfi_req | input | 1 | Hart enters wait-for-interrupt |
| take_irq | output | 1 | An interrupt is taken this cycle |
| take_cause | output | 4 | Index of the winning interrupt bit |
| take_mode | output | 2 | Mode that handles the taken interrupt |
| wfi_stall | output | 1 | Hart is held waiting for an interrupt |
| wfi_wake | output | 1 | Stalled and a nonzero vector is pending |

## Verification
One interrupt is driven under each pairing of current mode and target level, with the governing enable flipped. This separates the same-level gate from the always-on higher level and the always-off lower level. Undelegated supervisor bits are checked with sie_bit toggled, to show that the supervisor enable is ignored for them. Vectors with several bits set run the within-level order pair by pair and the rule that M-targeted interrupts win over S-targeted ones. Vectors holding only even bits, or vectors whose bits are all delegated while the hart is in M-mode, show that a pending vector can wake the hart without any interrupt being taken.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NIRQ = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NIRQ-1:0]         irq_pend,
  input  logic [NIRQ-1:0]         irq_deleg,
  input  logic [1:0]              priv_mode,
  input  logic                    mie_bit,
  input  logic                    sie_bit,
  input  logic                    wfi_req,
  output logic                    take_irq,
  output logic [$clog2(NIRQ)-1:0] take_cause,
  output logic [1:0]              take_mode,
  output logic                    wfi_stall,
  output logic                    wfi_wake
);
  localparam int CW = $clog2(NIRQ);
  localparam int NPRIO = 6;
  localparam logic [1:0] MODE_U = 2'b00;
  localparam logic [1:0] MODE_S = 2'b01;
  localparam logic [1:0] MODE_M = 2'b11;
  localparam logic [NIRQ-1:0] ARB_MASK = NIRQ'(12'hAAA);
  localparam int PRIO [NPRIO] = '{11, 3, 7, 9, 1, 5};

  function automatic logic [CW-1:0] pick(input logic [NIRQ-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int k = NPRIO - 1; k >= 0; k--)
      if (v[PRIO[k]]) r = CW'(PRIO[k]);
    return r;
  endfunction

  logic            m_ok, s_ok, m_any, s_any, any_pend, stall_q;
  logic [NIRQ-1:0] m_cand, s_cand;

  assign m_ok = (priv_mode != MODE_M) | mie_bit;
  assign s_ok = (priv_mode == MODE_U) | ((priv_mode == MODE_S) & sie_bit);

  assign m_cand = irq_pend & ~irq_deleg & ARB_MASK & {NIRQ{m_ok}};
  assign s_cand = irq_pend &  irq_deleg & ARB_MASK & {NIRQ{s_ok}};
  assign m_any  = |m_cand;
  assign s_any  = |s_cand;

  assign take_irq   = m_any | s_any;
  assign take_cause = m_any ? pick(m_cand) : (s_any ? pick(s_cand) : '0);
  assign take_mode  = m_any ? MODE_M : (s_any ? MODE_S : MODE_U);

  assign any_pend = |irq_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_q <= 1'b0;
    else if (any_pend) stall_q <= 1'b0;
    else if (wfi_req)  stall_q <= 1'b1;
  end

  assign wfi_stall = stall_q;
  assign wfi_wake  = stall_q & any_pend;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NIRQ = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NIRQ-1:0]         irq_pend,
  input logic [NIRQ-1:0]         irq_deleg,
  input logic [1:0]              priv_mode,
  input logic                    mie_bit,
  input logic                    wfi_req,
  input logic                    take_irq,
  input logic [$clog2(NIRQ)-1:0] take_cause,
  input logic [1:0]              take_mode,
  input logic                    wfi_stall
);
  localparam logic [NIRQ-1:0] ODD = NIRQ'(12'hAAA);

  // R1
  m_target_undelegated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && take_mode == 2'b11) |-> !irq_deleg[take_cause]);

  // R2
  m_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_mode == 2'b11 && !mie_bit) |-> !take_irq);

  // R5
  no_lower_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_mode == 2'b11 && take_irq) |-> take_mode == 2'b11);

  // R7
  m_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && take_mode == 2'b01) |-> ((irq_pend & ~irq_deleg & ODD) == '0));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> (take_cause == '0 && take_mode == 2'b00));

  // R10
  odd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend & ODD) == '0) |-> !take_irq);

  // R11
  wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend != '0) |=> !wfi_stall);

  // R11
  stall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wfi_req && irq_pend == '0) |=> wfi_stall);
endmodule

bind irq_arbiter irq_arbiter_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_deleg(irq_deleg),
  .priv_mode(priv_mode), .mie_bit(mie_bit), .wfi_req(wfi_req),
  .take_irq(take_irq), .take_cause(take_cause), .take_mode(take_mode),
  .wfi_stall(wfi_stall)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] irq_pend = '0;
  logic [11:0] irq_deleg = '0;
  logic [1:0]  priv_mode = 2'b11;
  logic        mie_bit = 1'b0;
  logic        sie_bit = 1'b0;
  logic        wfi_req = 1'b0;
  logic        take_irq;
  logic [3:0]  take_cause;
  logic [1:0]  take_mode;
  logic        wfi_stall;
  logic        wfi_wake;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter u0 (.*);

  localparam int NV = 21;
  // {pend, deleg, mode, mie, sie, exp_take, exp_cause, exp_mode}
  localparam logic [34:0] VEC [NV] = '{
    {12'h002, 12'h000, 2'b01, 1'b1, 1'b0, 1'b1, 4'd1,  2'b11}, // R1 example
    {12'h002, 12'h000, 2'b11, 1'b1, 1'b1, 1'b1, 4'd1,  2'b11}, // R1
    {12'h002, 12'h000, 2'b11, 1'b0, 1'b1, 1'b0, 4'd0,  2'b00}, // R1 sie ignored
    {12'h002, 12'h000, 2'b01, 1'b0, 1'b0, 1'b1, 4'd1,  2'b11}, // R3
    {12'h080, 12'h000, 2'b00, 1'b0, 1'b0, 1'b1, 4'd7,  2'b11}, // R3
    {12'h080, 12'h000, 2'b11, 1'b0, 1'b1, 1'b0, 4'd0,  2'b00}, // R2
    {12'h080, 12'h000, 2'b11, 1'b1, 1'b0, 1'b1, 4'd7,  2'b11}, // R2
    {12'h020, 12'h020, 2'b01, 1'b1, 1'b0, 1'b0, 4'd0,  2'b00}, // R4
    {12'h020, 12'h020, 2'b01, 1'b0, 1'b1, 1'b1, 4'd5,  2'b01}, // R4
    {12'h200, 12'h200, 2'b11, 1'b1, 1'b1, 1'b0, 4'd0,  2'b00}, // R5
    {12'h008, 12'h008, 2'b11, 1'b1, 1'b1, 1'b0, 4'd0,  2'b00}, // R5
    {12'h200, 12'h200, 2'b00, 1'b0, 1'b0, 1'b1, 4'd9,  2'b01}, // R6
    {12'h802, 12'h800, 2'b01, 1'b0, 1'b1, 1'b1, 4'd1,  2'b11}, // R7
    {12'h0A0, 12'h020, 2'b01, 1'b0, 1'b1, 1'b1, 4'd7,  2'b11}, // R7
    {12'h808, 12'h000, 2'b00, 1'b0, 1'b0, 1'b1, 4'd11, 2'b11}, // R8
    {12'h288, 12'h000, 2'b11, 1'b1, 1'b0, 1'b1, 4'd3,  2'b11}, // R8
    {12'h282, 12'h000, 2'b11, 1'b1, 1'b0, 1'b1, 4'd7,  2'b11}, // R8
    {12'h222, 12'h000, 2'b01, 1'b0, 1'b0, 1'b1, 4'd9,  2'b11}, // R8
    {12'h022, 12'h022, 2'b00, 1'b0, 1'b0, 1'b1, 4'd1,  2'b01}, // R8
    {12'h000, 12'hFFF, 2'b00, 1'b1, 1'b1, 1'b0, 4'd0,  2'b00}, // R9
    {12'h555, 12'h000, 2'b11, 1'b1, 1'b1, 1'b0, 4'd0,  2'b00}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    irq_pend = 12'h004;
    #7;
    check("R12", {30'd0, wfi_stall, wfi_wake}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    irq_pend = '0;
    #1;
    check("R12", {30'd0, wfi_stall, wfi_wake}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {irq_pend, irq_deleg, priv_mode, mie_bit, sie_bit} = VEC[i][34:7];
      #1;
      check($sformatf("vector %0d (R1-group)", i), {25'd0, take_irq, take_cause, take_mode},
            {25'd0, VEC[i][6:0]});
    end

    // R11: enter stall
    @(negedge clk);
    irq_pend = '0;
    wfi_req = 1'b1;
    @(negedge clk);
    wfi_req = 1'b0;
    #1;
    check("R11 stall set", {31'd0, wfi_stall}, 32'd1);
    check("R11 no wake", {31'd0, wfi_wake}, 32'd0);
    @(negedge clk);
    #1;
    check("R11 stall held", {31'd0, wfi_stall}, 32'd1);

    // R11: even bit wakes without a take
    @(negedge clk);
    irq_pend = 12'h004;
    #1;
    check("R11 wake", {30'd0, wfi_wake, take_irq}, 32'b10);
    @(negedge clk);
    irq_pend = '0;
    #1;
    check("R11 stall cleared", {30'd0, wfi_stall, wfi_wake}, 32'd0);

    // R11: delegated bit in M-mode wakes without a take
    @(negedge clk);
    wfi_req = 1'b1;
    @(negedge clk);
    wfi_req = 1'b0;
    irq_deleg = 12'h008;
    priv_mode = 2'b11;
    irq_pend = 12'h008;
    #1;
    check("R11 wake masked", {30'd0, wfi_wake, take_irq}, 32'b10);
    @(negedge clk);
    irq_pend = '0;
    #1;
    check("R11 stall cleared masked", {31'd0, wfi_stall}, 32'd0);

    // R11: pending vector overrides wfi_req
    @(negedge clk);
    irq_pend = 12'h001;
    wfi_req = 1'b1;
    @(negedge clk);
    wfi_req = 1'b0;
    irq_pend = '0;
    #1;
    check("R11 override", {31'd0, wfi_stall}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule